// File: doc/BRIEF.md
# Single-Button Decimal Stopwatch Core

This block keeps elapsed time from 00.00 to 99.99 seconds as four binary-coded decimal digits. A prescaler divides the system clock into a one-cycle tick at 100 Hz. That tick advances a chain of four decade counters: hundredths, tenths, seconds and tens of seconds. Each counter passes a carry-enable to the next more significant one.

One pushbutton drives a small controller. The first press starts the watch, the second press freezes the count and the third press returns every digit to zero. The button level arriving here must already be debounced and synchronized to the clock. The digit outputs go to a display driver outside this block. For fast simulation the clock and tick rates are parameters, so the tick can come every few cycles instead of every 100,000.

Top module: `stopwatch_core`

## Requirements
- R1: While `rst_n` is low, at the following clock edge all four digits become 0 and `running` becomes 0.
- R2: The prescaler tick repeats every CLK_HZ/TICK_HZ clock cycles and is free-running from reset. While running, the hundredths digit changes exactly once per tick period.
- R3: A rising edge of `btn` seen in the idle state makes `running` go high after the next clock edge. Digits stay at 0 while idle.
- R4: A rising edge of `btn` while running makes `running` go low. After that the digits hold their value.
- R5: A rising edge of `btn` while stopped clears all four digits to 0 at the next clock edge and returns the controller to idle. Clear takes priority over counting.
- R6: Holding `btn` high for many cycles counts as one press: the controller steps once per 0-to-1 transition only.
- R7: Every digit stays within 0..9. A digit advances on a tick only when all less significant digits are 9 (carry ripple), so the four digits together read the count of ticks since start, in decimal.
- R8: On the tick after 99.99 all digits wrap to 00.00 and `running` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (10 MHz by default) |
| rst_n | input | 1 | Synchronous reset, active low |
| btn | input | 1 | Debounced, synchronized button level |
| tens_s | output | 4 | BCD tens-of-seconds digit |
| ones_s | output | 4 | BCD seconds digit |
| tenths_s | output | 4 | BCD tenths digit |
| hundredths_s | output | 4 | BCD hundredths digit |
| running | output | 1 | High while the watch is counting |

## Verification
A button edge registered at a clock edge changes `running` or clears the digits at that same edge, so the new value can be read half a cycle later. A tick moves the digits at the edge where the prescaler reaches its terminal count. The bench drives inputs on falling edges. Its behavioural model steps on each rising edge from the same inputs, and the outputs are compared against it on each following falling edge. Directed checks then read the reset, start, stop, clear, hold-down, tick spacing and wrap cases at those same half-cycle points.

// File: rtl/sw_pkg.sv
// Shared types and constants for the stopwatch core.
package sw_pkg;
    localparam int DIGIT_W = 4;   // one BCD digit
    localparam int NDIG    = 4;   // hundredths .. tens of seconds

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_RUN  = 2'd1,
        SW_HOLD = 2'd2
    } sw_state_t;
endpackage

// File: rtl/sw_prescaler.sv
// Free-running divider: emits a one-cycle tick every DIV clocks.
// Assumes DIV >= 2 and a synchronous active-low reset.
module sw_prescaler #(
    parameter int DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == LAST);

    // advance the divider, wrapping on the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sw_ctrl.sv
// One-button controller: start -> stop -> clear, stepped by the rising
// edge of an already debounced and synchronized button level.
module sw_ctrl
    import sw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    output logic run_en,
    output logic clr
);
    sw_state_t state, state_nx;
    logic      btn_q;
    logic      press;

    assign press  = btn & ~btn_q;
    assign run_en = (state == SW_RUN);
    assign clr    = press & (state == SW_HOLD);

    // next-state selection on a press
    always_comb begin
        state_nx = state;
        if (press) begin
            case (state)
                SW_IDLE: state_nx = SW_RUN;
                SW_RUN:  state_nx = SW_HOLD;
                SW_HOLD: state_nx = SW_IDLE;
                default: state_nx = SW_IDLE;
            endcase
        end
    end

    // state and button-history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SW_IDLE;
            btn_q <= 1'b0;
        end else begin
            state <= state_nx;
            btn_q <= btn;
        end
    end
endmodule

// File: rtl/sw_digit.sv
// Single decade counter with carry-enable out. Clear is synchronous
// and wins over enable; carry is combinational from en_in and terminal.
module sw_digit #(
    parameter int W    = 4,
    parameter int MAXV = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_in,
    input  logic         clr,
    output logic [W-1:0] q,
    output logic         en_out
);
    localparam logic [W-1:0] TOP = W'(MAXV);

    assign en_out = en_in & (q == TOP);

    // count with clear priority and wrap at TOP
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= '0;
        else if (en_in)
            q <= (q == TOP) ? '0 : q + 1'b1;
    end
endmodule

// File: rtl/stopwatch_core.sv
// Stopwatch core: prescaler tick gated by the controller drives a ripple
// chain of decade digits. Button must be debounced and synchronized.
module stopwatch_core
    import sw_pkg::*;
#(
    parameter int CLK_HZ  = 10_000_000,
    parameter int TICK_HZ = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               btn,
    output logic [DIGIT_W-1:0] tens_s,
    output logic [DIGIT_W-1:0] ones_s,
    output logic [DIGIT_W-1:0] tenths_s,
    output logic [DIGIT_W-1:0] hundredths_s,
    output logic               running
);
    localparam int DIV = CLK_HZ / TICK_HZ;

    logic                tick;
    logic                run_en;
    logic                clr;
    logic [NDIG:0]       en_chain;
    logic [DIGIT_W-1:0]  dig [NDIG];

    sw_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sw_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .btn    (btn),
        .run_en (run_en),
        .clr    (clr)
    );

    assign en_chain[0] = tick & run_en;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        sw_digit #(.W(DIGIT_W), .MAXV(9)) u_digit (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_in  (en_chain[i]),
            .clr    (clr),
            .q      (dig[i]),
            .en_out (en_chain[i+1])
        );
    end

    assign hundredths_s = dig[0];
    assign tenths_s     = dig[1];
    assign ones_s       = dig[2];
    assign tens_s       = dig[3];
    assign running      = run_en;
endmodule

// File: rtl/sw_core_checker.sv
// Port-level properties for stopwatch_core, attached by bind.
module sw_core_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       btn,
    input logic [3:0] tens_s,
    input logic [3:0] ones_s,
    input logic [3:0] tenths_s,
    input logic [3:0] hundredths_s,
    input logic       running
);
    logic [15:0] all_d;
    assign all_d = {tens_s, ones_s, tenths_s, hundredths_s};

    // R1: reset drives digits and run flag to zero
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (all_d == 16'h0 && !running));

    // R7: every digit stays decimal
    a_r7_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tens_s <= 4'd9 && ones_s <= 4'd9 && tenths_s <= 4'd9 && hundredths_s <= 4'd9));

    // R3: running only rises after a 0-to-1 button transition
    a_r3_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> ($past(btn) && !$past(btn, 2)));

    // R4: while stopped, digits either hold or were cleared to zero
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(running) |-> ($stable(all_d) || all_d == 16'h0));

    // R6: a held button does not step the controller
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (btn && $past(btn)) |=> $stable(running));

    // R8: hundredths only steps by one (mod 10)
    a_r8_hund_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && !$stable(hundredths_s) && hundredths_s != 4'd0)
            |-> (hundredths_s == $past(hundredths_s) + 4'd1));
endmodule

bind stopwatch_core sw_core_checker u_chk (.*);

// File: tb/stopwatch_core_tb.sv
module stopwatch_core_tb;
    localparam int CLK_HZ  = 400;
    localparam int TICK_HZ = 100;
    localparam int DIV     = CLK_HZ / TICK_HZ;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn = 1'b0;
    logic [3:0] tens_s, ones_s, tenths_s, hundredths_s;
    logic       running;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // behavioural reference model
    int m_pcnt = 0, m_st = 0, m_cnt = 0;
    bit m_bprev = 0;

    always #2 clk = ~clk;

    stopwatch_core #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .btn(btn),
        .tens_s(tens_s), .ones_s(ones_s), .tenths_s(tenths_s),
        .hundredths_s(hundredths_s), .running(running)
    );

    always @(posedge clk) begin
        bit press, tick;
        if (!rst_n) begin
            m_pcnt = 0; m_st = 0; m_cnt = 0; m_bprev = 0;
        end else begin
            press = btn && !m_bprev;
            tick  = (m_pcnt == DIV - 1);
            m_pcnt = tick ? 0 : m_pcnt + 1;
            m_bprev = btn;
            if (m_st == 2 && press) begin
                m_cnt = 0; m_st = 0;
            end else begin
                if (m_st == 1 && tick) m_cnt = (m_cnt + 1) % 10000;
                if (press) m_st = (m_st + 1) % 3;
            end
        end
    end

    function automatic int dut_val();
        return tens_s * 1000 + ones_s * 100 + tenths_s * 10 + hundredths_s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle model comparison (R7 value, R3/R4 run flag)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 model value", dut_val(), m_cnt);
            check("R3 model running", int'(running), int'(m_st == 1));
        end
    end

    task automatic press(input int hold);
        @(negedge clk) btn = 1'b1;
        repeat (hold) @(negedge clk);
        btn = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int held, gap, prev;
        repeat (5) @(negedge clk);
        check("R1 reset digits", dut_val(), 0);
        check("R1 reset running", int'(running), 0);
        rst_n = 1'b1;

        repeat (20) @(negedge clk);
        check("R3 idle digits stay zero", dut_val(), 0);

        press(10);
        check("R3 started", int'(running), 1);
        check("R6 long hold single step", int'(running), 1);

        repeat (100) @(negedge clk);
        // R2: measure spacing between hundredths changes
        prev = hundredths_s;
        while (hundredths_s == prev) @(negedge clk);
        prev = hundredths_s; gap = 0;
        while (hundredths_s == prev) begin @(negedge clk); gap++; end
        check("R2 tick spacing", gap, DIV);

        press(1);
        check("R4 stopped", int'(running), 0);
        held = dut_val();
        repeat (50) @(negedge clk);
        check("R4 digits hold", dut_val(), held);

        press(3);
        check("R5 cleared", dut_val(), 0);
        check("R5 idle after clear", int'(running), 0);

        press(1);
        check("R3 restarted", int'(running), 1);
        while (dut_val() != 99) @(negedge clk);
        while (dut_val() == 99) @(negedge clk);
        check("R7 carry 0099->0100", dut_val(), 100);
        while (dut_val() != 9999) @(negedge clk);
        check("R8 reached 99.99", dut_val(), 9999);
        while (dut_val() == 9999) @(negedge clk);
        check("R8 wrapped to 00.00", dut_val(), 0);
        check("R8 still running", int'(running), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule